// File: doc/BRIEF.md
# 64-bit Alarm Timer with Coherent Snapshot

This block is a general-purpose timer. Its counter is two register words wide, counts up or down once per prescaled tick, and is driven from a programmable clock divider. Software sees the block through a small word-addressed register port. A read request travels on a valid/ready channel, and its data comes back on a second valid/ready channel. The block also drives one level interrupt line.

The counter cannot be read directly. Software writes to a snapshot trigger word, which copies the whole live count into a pair of read-only words, so both halves come from the same instant. Loading works the same way: software writes a load value as two halves, and the count takes it only when the load trigger word is written. A two-word alarm comparator checks the count on every tick. When it matches, it raises a sticky status flag, and it can also reload the counter from the load value.

Back-pressure: a request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is pending and `rsp_ready` is low. A read response holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` takes it. Writes never produce a response.

Top module: `tmr_alarm_timer`

## Requirements
- R1: Bit 0 of the control word (address 0) enables counting. While it is clear, the counter keeps its value indefinitely.
- R2: Bit 1 of the control word selects the count direction: 1 counts up and 0 counts down. The count wraps modulo 2^(2*DATA_W) in both directions.
- R3: The divider word (address 1, PRE_W bits, reset value 1) sets the cycles per tick. A value of 0 gives 2^PRE_W cycles, 1 and 2 both give 2 cycles, and any other value N gives N cycles. The first tick comes N cycles after counting is enabled.
- R4: Any write to address 2 copies the live count into the snapshot words: low half at address 3, high half at address 4. The snapshot then stays unchanged until the next such write.
- R5: The load value is written as a low half (address 5) and a high half (address 6), and both read back. Any write to address 7 places the load value in the counter at once, whether or not counting is enabled.
- R6: The alarm value is held as a low half (address 8) and a high half (address 9), and both read back. A match, meaning the count equals the alarm value on a tick, is recognised only while control bit 2 is set.
- R7: When control bit 3 is set, a match reloads the counter from the load value. When bit 3 is clear, the counter keeps counting past the alarm.
- R8: Bit 0 of the status word (address 11) is set by a match and stays set. Writing a 1 to bit 0 of address 12 clears it, and writing 0 there has no effect.
- R9: `irq_o` is high exactly when the status bit, control bit 4 and bit 0 of the interrupt enable word (address 10) are all set.
- R10: After reset, the control word is 0, the counter is 0, the divider word is 1, the status bit is 0 and `irq_o` is low.
- R11: A read returns its data one cycle after acceptance and holds it until `rsp_ready`. `req_ready` is low while a response is stalled. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | DATA_W | Read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with DATA_W = 8 and PRE_W = 4, which makes the counter 16 bits wide. At that width a short down-count crosses zero, so the wrap in both halves of the snapshot becomes observable. The divide-by-2^PRE_W case then costs only 16 cycles per tick, so the zero encoding of the divider can be measured directly, together with the 1, 2 and N encodings. Alarm runs are kept short enough to show a reload followed by further counting, and a continued count with the reload turned off.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL      = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIV       = 4'd1;
  localparam logic [ADDR_W-1:0] A_SNAP_TRIG = 4'd2;
  localparam logic [ADDR_W-1:0] A_SNAP_LO   = 4'd3;
  localparam logic [ADDR_W-1:0] A_SNAP_HI   = 4'd4;
  localparam logic [ADDR_W-1:0] A_LOAD_LO   = 4'd5;
  localparam logic [ADDR_W-1:0] A_LOAD_HI   = 4'd6;
  localparam logic [ADDR_W-1:0] A_LOAD_TRIG = 4'd7;
  localparam logic [ADDR_W-1:0] A_ALARM_LO  = 4'd8;
  localparam logic [ADDR_W-1:0] A_ALARM_HI  = 4'd9;
  localparam logic [ADDR_W-1:0] A_IRQ_EN    = 4'd10;
  localparam logic [ADDR_W-1:0] A_IRQ_STAT  = 4'd11;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR   = 4'd12;

  localparam int CTRL_W   = 5;
  localparam int B_RUN    = 0;
  localparam int B_UP     = 1;
  localparam int B_ALARM  = 2;
  localparam int B_RELOAD = 3;
  localparam int B_LVL    = 4;

  typedef struct packed {
    logic lvl_en;
    logic reload;
    logic alarm_en;
    logic up;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  localparam int LIM_W = PRE_W + 1;

  logic [LIM_W-1:0] lim;
  logic [LIM_W-1:0] phase;

  always_comb begin
    if (div == '0)
      lim = {1'b0, {PRE_W{1'b1}}};
    else if (div <= PRE_W'(2))
      lim = LIM_W'(1);
    else
      lim = {1'b0, div} - LIM_W'(1);
  end

  assign tick = run && (phase >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase <= '0;
    else if (!run || tick)
      phase <= '0;
    else
      phase <= phase + LIM_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             up,
  input  logic             alarm_en,
  input  logic             reload,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  assign match = tick && alarm_en && (cnt == alarm_val);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load_now)
      cnt <= load_val;
    else if (match && reload)
      cnt <= load_val;
    else if (tick)
      cnt <= up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_now) |=> $stable(cnt)); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && up && !load_now && !(match && reload)) |=> cnt == $past(cnt) + CNT_W'(1)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !up && !load_now && !(match && reload)) |=> cnt == $past(cnt) - CNT_W'(1)); // R2
  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> cnt == $past(load_val)); // R5
  AST_ALARM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (match && reload && !load_now) |=> cnt == $past(load_val)); // R7
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic clr,
  input  logic ien,
  input  logic lvl_en,
  output logic stat,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      stat <= 1'b0;
    else if (match)
      stat <= 1'b1;
    else if (clr)
      stat <= 1'b0;
  end

  assign irq = stat && ien && lvl_en;

  AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> stat); // R8
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !clr) |=> stat); // R8
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match) |=> !stat); // R8
endmodule

// File: rtl/tmr_alarm_timer.sv
module tmr_alarm_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [3:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_o
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int HALVES = 2;

  ctrl_t             ctrl_q;
  logic [PRE_W-1:0]  div_q;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  alarm_q;
  logic [CNT_W-1:0]  snap_q;
  logic              ien_q;
  logic [CNT_W-1:0]  cnt;
  logic              tick;
  logic              match;
  logic              stat;
  logic              wr_fire;
  logic              rd_fire;
  logic              load_now;
  logic              irq_clr;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign wr_fire   = req_valid && req_ready && req_write;
  assign rd_fire   = req_valid && req_ready && !req_write;
  assign load_now  = wr_fire && (req_addr == A_LOAD_TRIG);
  assign irq_clr   = wr_fire && (req_addr == A_IRQ_CLR) && req_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= PRE_W'(1);
      ien_q  <= 1'b0;
      snap_q <= '0;
    end else if (wr_fire) begin
      case (req_addr)
        A_CTRL:      ctrl_q <= ctrl_t'(req_wdata[CTRL_W-1:0]);
        A_DIV:       div_q  <= req_wdata[PRE_W-1:0];
        A_IRQ_EN:    ien_q  <= req_wdata[0];
        A_SNAP_TRIG: snap_q <= cnt;
        default: ;
      endcase
    end
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        load_q[h*DATA_W +: DATA_W]  <= '0;
        alarm_q[h*DATA_W +: DATA_W] <= '0;
      end else if (wr_fire) begin
        if (req_addr == 4'(A_LOAD_LO + h))
          load_q[h*DATA_W +: DATA_W] <= req_wdata;
        if (req_addr == 4'(A_ALARM_LO + h))
          alarm_q[h*DATA_W +: DATA_W] <= req_wdata;
      end
    end
  end

  always_comb begin
    case (req_addr)
      A_CTRL:     rd_mux = DATA_W'(ctrl_q);
      A_DIV:      rd_mux = DATA_W'(div_q);
      A_SNAP_LO:  rd_mux = snap_q[DATA_W-1:0];
      A_SNAP_HI:  rd_mux = snap_q[CNT_W-1:DATA_W];
      A_LOAD_LO:  rd_mux = load_q[DATA_W-1:0];
      A_LOAD_HI:  rd_mux = load_q[CNT_W-1:DATA_W];
      A_ALARM_LO: rd_mux = alarm_q[DATA_W-1:0];
      A_ALARM_HI: rd_mux = alarm_q[CNT_W-1:DATA_W];
      A_IRQ_EN:   rd_mux = DATA_W'(ien_q);
      A_IRQ_STAT: rd_mux = DATA_W'(stat);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (rsp_valid && rsp_ready)
        rsp_valid <= 1'b0;
      if (rd_fire) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_mux;
      end
    end
  end

  tmr_presc #(.PRE_W(PRE_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl_q.run),
    .div  (div_q),
    .tick (tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .up       (ctrl_q.up),
    .alarm_en (ctrl_q.alarm_en),
    .reload   (ctrl_q.reload),
    .load_now (load_now),
    .load_val (load_q),
    .alarm_val(alarm_q),
    .cnt      (cnt),
    .match    (match)
  );

  tmr_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .match (match),
    .clr   (irq_clr),
    .ien   (ien_q),
    .lvl_en(ctrl_q.lvl_en),
    .stat  (stat),
    .irq   (irq_o)
  );

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R11
  AST_HALTED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !load_now) |=> $stable(cnt)); // R1
  AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && req_addr == A_SNAP_TRIG) |=> $stable(snap_q)); // R4
endmodule

// File: tb/tmr_alarm_timer_tb.sv
module tmr_alarm_timer_tb;
  import tmr_pkg::*;
  localparam int DW = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [3:0]    req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic          irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  tmr_alarm_timer #(.DATA_W(DW), .PRE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a response is taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected response", rsp_rdata, 0);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  task automatic bus(input logic w, input logic [3:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    bus(1'b1, a, d);
  endtask

  task automatic rd(input logic [3:0] a, input logic [DW-1:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus(1'b0, a, '0);
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    idle(200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    @(posedge clk); #1; rst_n = 1'b1;

    // R10 reset state
    rd(A_CTRL, 8'h00, "R10 ctrl after reset");
    rd(A_DIV, 8'h01, "R10 divider after reset");
    rd(A_IRQ_STAT, 8'h00, "R10 status after reset");
    check(irq_o == 1'b0, "R10 irq after reset", irq_o, 0);
    wr(A_SNAP_TRIG, 8'h00);
    rd(A_SNAP_LO, 8'h00, "R10 counter zero lo");
    rd(A_SNAP_HI, 8'h00, "R10 counter zero hi");
    rd(4'd15, 8'h00, "R11 unused address");

    // R5 load trigger
    wr(A_LOAD_LO, 8'h34);
    wr(A_LOAD_HI, 8'h12);
    rd(A_LOAD_LO, 8'h34, "R5 load lo readback");
    wr(A_LOAD_TRIG, 8'h00);
    wr(A_SNAP_TRIG, 8'h00);
    rd(A_SNAP_LO, 8'h34, "R5 loaded lo");
    rd(A_SNAP_HI, 8'h12, "R5 loaded hi");

    // R3 divide by 5, 16 active edges -> 3 ticks up
    wr(A_DIV, 8'd5);
    wr(A_CTRL, 8'h03);
    idle(14);
    wr(A_CTRL, 8'h02);
    wr(A_SNAP_TRIG, 8'h00);
    rd(A_SNAP_LO, 8'h37, "R3 divide by 5");
    // R1 halted counter keeps value
    idle(20);
    wr(A_SNAP_TRIG, 8'h00);
    rd(A_SNAP_LO, 8'h37, "R1 halted lo");
    rd(A_SNAP_HI, 8'h12, "R1 halted hi");

    // R4 snapshot not refreshed by a load
    wr(A_LOAD_LO, 8'h00);
    wr(A_LOAD_HI, 8'h00);
    wr(A_LOAD_TRIG, 8'h00);
    rd(A_SNAP_LO, 8'h37, "R4 snapshot held");

    // R2 down count through zero, divider 1 -> 2 cycles, 8 ticks from 5
    wr(A_DIV, 8'd1);
    wr(A_LOAD_LO, 8'h05);
    wr(A_LOAD_TRIG, 8'h00);
    wr(A_CTRL, 8'h01);
    idle(14);
    wr(A_CTRL, 8'h00);
    wr(A_SNAP_TRIG, 8'h00);
    rd(A_SNAP_LO, 8'hFD, "R2 down wrap lo");
    rd(A_SNAP_HI, 8'hFF, "R2 down wrap hi");

    // R3 divider 0 -> 16 cycles, 34 edges -> 2 ticks
    wr(A_LOAD_LO, 8'h00);
    wr(A_LOAD_TRIG, 8'h00);
    wr(A_DIV, 8'd0);
    wr(A_CTRL, 8'h03);
    idle(32);
    wr(A_CTRL, 8'h02);
    wr(A_SNAP_TRIG, 8'h00);
    rd(A_SNAP_LO, 8'h02, "R3 divider zero");

    // R3 divider 2 -> 2 cycles, 6 edges -> 3 ticks
    wr(A_DIV, 8'd2);
    wr(A_LOAD_TRIG, 8'h00);
    wr(A_CTRL, 8'h03);
    idle(4);
    wr(A_CTRL, 8'h02);
    wr(A_SNAP_TRIG, 8'h00);
    rd(A_SNAP_LO, 8'h03, "R3 divider two");

    // R6 alarm gated off, R7 continue past alarm
    wr(A_DIV, 8'd1);
    wr(A_ALARM_LO, 8'h03);
    wr(A_ALARM_HI, 8'h00);
    rd(A_ALARM_LO, 8'h03, "R6 alarm lo readback");
    rd(A_ALARM_HI, 8'h00, "R6 alarm hi readback");
    wr(A_LOAD_TRIG, 8'h00);
    wr(A_CTRL, 8'h03);
    idle(18);
    wr(A_CTRL, 8'h02);
    rd(A_IRQ_STAT, 8'h00, "R6 no match while alarm disabled");
    wr(A_LOAD_TRIG, 8'h00);
    wr(A_CTRL, 8'h07);
    idle(18);
    wr(A_CTRL, 8'h06);
    wr(A_SNAP_TRIG, 8'h00);
    rd(A_SNAP_LO, 8'h0A, "R7 counts past alarm");
    rd(A_IRQ_STAT, 8'h01, "R6 match sets status");

    // R9 interrupt gating, R8 clear
    check(irq_o == 1'b0, "R9 irq off with no enables", irq_o, 0);
    wr(A_IRQ_EN, 8'h01);
    check(irq_o == 1'b0, "R9 irq off without level enable", irq_o, 0);
    wr(A_CTRL, 8'h16);
    check(irq_o == 1'b1, "R9 irq on with both enables", irq_o, 1);
    wr(A_IRQ_CLR, 8'h00);
    rd(A_IRQ_STAT, 8'h01, "R8 clear with zero ignored");
    check(irq_o == 1'b1, "R8 irq kept after zero clear", irq_o, 1);
    wr(A_IRQ_CLR, 8'h01);
    rd(A_IRQ_STAT, 8'h00, "R8 clear acknowledges");
    check(irq_o == 1'b0, "R9 irq drops after clear", irq_o, 0);

    // R7 auto reload: start 0, alarm 3, reload 0x10, 10 ticks -> 0x16
    wr(A_LOAD_TRIG, 8'h00);
    wr(A_LOAD_LO, 8'h10);
    wr(A_CTRL, 8'h1F);
    idle(18);
    wr(A_CTRL, 8'h1E);
    wr(A_SNAP_TRIG, 8'h00);
    rd(A_SNAP_LO, 8'h16, "R7 auto reload");
    check(irq_o == 1'b1, "R9 irq from reload match", irq_o, 1);

    // R11 back-pressure on the response
    @(posedge clk); #1; rsp_ready = 1'b0;
    rd(A_CTRL, 8'h1E, "R11 stalled read data");
    idle(3);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R11 response held", rsp_valid, 1);
    check(req_ready == 1'b0, "R11 request stalled", req_ready, 0);
    @(posedge clk); #1; rsp_ready = 1'b1;
    idle(4);
    check(exp_q.size() == 0, "R11 all responses delivered", exp_q.size(), 0);

    finish_run();
  end
endmodule